// File: doc/BRIEF.md
# Root Port Status and Control Register

This block holds the status and control dword of a single root-hub port. Software reaches it over a plain 32-bit register interface: a write presents a full dword, and the read value is always available as a combinational view of the register. The port's physical side drives sampled inputs: attach state, over-current, the speed code found by link training, and pulses for reset completion, warm-reset completion, a link state report and a configuration failure. The block turns these into status bits and into sticky change flags that software clears by writing ones.

Software powers the port, selects the indicator colour and the wake enables, and starts hot or warm resets. It can also ask for a new link state. A link state request only takes effect when the strobe bit is set in the same write. The block presents each request to the physical side as a one-cycle request with the wanted state. Hot and warm resets are tracked by separate completion flags. A warm reset finishes by raising both the reset-change and the warm-reset-change flags. A hot reset raises only the reset-change flag.

Top module: `rport_ctl`

## Requirements
- R1: After reset, the read value is 0x0000_00A0: the link state field (bits 8:5) holds 5 and every other bit is 0. All outputs are 0.
- R2: Bit 0 follows `hw_connect` one clock later. Any change of that bit sets connect-change (bit 17). Bit 3 follows `hw_overcurrent` one clock later, and any change of bit 3 sets over-current-change (bit 20). A `hw_cfg_err` pulse sets config-error-change (bit 23).
- R3: Change bits 17 to 23 are sticky. Writing 1 to a change bit clears it. Writing 0 leaves it unchanged. When a set event and a clearing write land in the same cycle, the bit ends up as 1.
- R4: Writing 1 to bit 4 while port power (bit 9) is 1 starts a hot reset: bit 4 reads 1 and `reset_req` is 1. The same write while power is 0 is ignored.
- R5: A `hw_reset_done` pulse during a hot reset has these effects on the next clock: bit 4 returns to 0, port-enabled (bit 1) becomes 1, and the speed field (bits 13:10) takes `hw_speed`. One clock after bit 4 falls, reset-change (bit 21) becomes 1.
- R6: Writing 1 to bit 31 while powered starts a warm reset: bits 31 and 4 both read 1, `warm_req` is 1 and `reset_req` is 0. `hw_reset_done` has no effect during a warm reset. A `hw_warm_done` pulse clears bits 31 and 4, sets bit 1, loads the speed field and sets warm-reset-change (bit 19). Bit 21 follows one clock later.
- R7: A disconnect (bit 0 falling) clears bit 1 and the speed field. It sets enable-change (bit 18) only if bit 1 was 1.
- R8: A write with bit 16 set loads bits 8:5 into the link state field. The next clock shows `link_req_valid` high for one cycle, with `link_req_state` equal to the written state. A write without bit 16 leaves the field unchanged and raises no request. Bit 16 always reads 0.
- R9: A `hw_link_chg` pulse loads `hw_link_state` into bits 8:5 and sets link-state-change (bit 22). When it coincides with a strobed software write, the hardware value ends up in the field, and the software request is still raised.
- R10: Bits 15:14 set the indicator code: 0 off, 1 amber, 2 green. The code appears on `led_code`. A write of code 3 leaves the previous code in place.
- R11: Every write loads port power (bit 9, `port_power`) and the wake enables (bits 27:25). Reserved bits 2, 24, 28, 29 and 30 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| hw_connect | input | 1 | Device attached |
| hw_overcurrent | input | 1 | Over-current active |
| hw_speed | input | 4 | Speed code found by link training |
| hw_link_chg | input | 1 | Pulse: link state report |
| hw_link_state | input | 4 | Reported link state |
| hw_reset_done | input | 1 | Pulse: hot reset finished |
| hw_warm_done | input | 1 | Pulse: warm reset finished |
| hw_cfg_err | input | 1 | Pulse: link partner configuration failed |
| port_power | output | 1 | Port power enable |
| reset_req | output | 1 | Hot reset request |
| warm_req | output | 1 | Warm reset request |
| link_req_valid | output | 1 | One-cycle link state request |
| link_req_state | output | 4 | Requested link state |
| led_code | output | 2 | Indicator code |

## Verification
The two functions that collide are a hardware event that sets a change flag and a software write that clears the same flag by writing a one. The bench provokes the collision by dropping `hw_connect` in the same cycle as a write that clears connect-change. The check passes if bit 17 still reads 1 afterwards and enable-change has also been raised. A second collision pairs a hardware link report with a strobed link state write. That check passes if the field holds the reported state while the request output carries the written one.

// File: rtl/rport_pkg.sv
package rport_pkg;
    localparam int REG_W  = 32;
    localparam int LS_W   = 4;
    localparam int SPD_W  = 4;
    localparam int LED_W  = 2;
    localparam int WAKE_W = 3;
    localparam int CHG_N  = 7;

    // bit positions inside the dword
    localparam int B_CONN = 0;
    localparam int B_EN   = 1;
    localparam int B_OC   = 3;
    localparam int B_RST  = 4;
    localparam int B_LS   = 5;
    localparam int B_PWR  = 9;
    localparam int B_SPD  = 10;
    localparam int B_LED  = 14;
    localparam int B_STB  = 16;
    localparam int B_CHG  = 17;
    localparam int B_WAKE = 25;
    localparam int B_WARM = 31;

    // change flag indices, offset from B_CHG
    localparam int C_CONN = 0;
    localparam int C_EN   = 1;
    localparam int C_WARM = 2;
    localparam int C_OC   = 3;
    localparam int C_RST  = 4;
    localparam int C_LINK = 5;
    localparam int C_CFG  = 6;

    localparam logic [LS_W-1:0] LS_RESET = 4'd5;

    typedef enum logic [LED_W-1:0] {
        LED_OFF   = 2'd0,
        LED_AMBER = 2'd1,
        LED_GREEN = 2'd2,
        LED_RSVD  = 2'd3
    } led_e;

    typedef struct packed {
        logic              conn;
        logic              en;
        logic              oc;
        logic              rst;
        logic              warm;
        logic              pwr;
        logic [LS_W-1:0]   ls;
        logic [SPD_W-1:0]  spd;
        led_e              led;
        logic [WAKE_W-1:0] wake;
    } port_state_t;

    function automatic logic led_legal(input logic [LED_W-1:0] code);
        return code != LED_RSVD;
    endfunction

    function automatic logic [REG_W-1:0] pack_dword(input port_state_t s,
                                                    input logic [CHG_N-1:0] chg);
        logic [REG_W-1:0] d;
        d = '0;
        d[B_CONN]           = s.conn;
        d[B_EN]             = s.en;
        d[B_OC]             = s.oc;
        d[B_RST]            = s.rst;
        d[B_LS +: LS_W]     = s.ls;
        d[B_PWR]            = s.pwr;
        d[B_SPD +: SPD_W]   = s.spd;
        d[B_LED +: LED_W]   = s.led;
        d[B_CHG +: CHG_N]   = chg;
        d[B_WAKE +: WAKE_W] = s.wake;
        d[B_WARM]           = s.warm;
        return d;
    endfunction
endpackage

// File: rtl/rport_sense.sv
module rport_sense
    import rport_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hw_connect,
    input  logic hw_overcurrent,
    output logic conn_q,
    output logic oc_q,
    output logic conn_tgl,
    output logic oc_tgl,
    output logic disc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            conn_q <= 1'b0;
            oc_q   <= 1'b0;
        end else begin
            conn_q <= hw_connect;
            oc_q   <= hw_overcurrent;
        end
    end

    assign conn_tgl = conn_q ^ hw_connect;
    assign oc_tgl   = oc_q ^ hw_overcurrent;
    assign disc     = conn_q & ~hw_connect;
endmodule

// File: rtl/rport_ctrl.sv
module rport_ctrl
    import rport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              pwr_wr,
    input  logic [LED_W-1:0]  led_wr,
    input  logic [WAKE_W-1:0] wake_wr,
    input  logic              rst_go,
    input  logic              warm_go,
    input  logic              stb_wr,
    input  logic [LS_W-1:0]   ls_wr,
    input  logic              disc,
    input  logic              hw_reset_done,
    input  logic              hw_warm_done,
    input  logic              hw_link_chg,
    input  logic [LS_W-1:0]   hw_link_state,
    input  logic [SPD_W-1:0]  hw_speed,
    output logic              en_q,
    output logic              rst_q,
    output logic              warm_q,
    output logic              pwr_q,
    output logic [LS_W-1:0]   ls_q,
    output logic [SPD_W-1:0]  spd_q,
    output led_e              led_q,
    output logic [WAKE_W-1:0] wake_q,
    output logic              link_req_valid,
    output logic [LS_W-1:0]   link_req_state,
    output logic              en_drop,
    output logic              warm_fin,
    output logic              rst_fell
);
    logic rst_d;
    logic hot_fin;

    assign hot_fin  = hw_reset_done & rst_q & ~warm_q;
    assign warm_fin = hw_warm_done & warm_q;
    assign en_drop  = disc & en_q;
    assign rst_fell = rst_d & ~rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q           <= 1'b0;
            rst_q          <= 1'b0;
            warm_q         <= 1'b0;
            pwr_q          <= 1'b0;
            ls_q           <= LS_RESET;
            spd_q          <= '0;
            led_q          <= LED_OFF;
            wake_q         <= '0;
            rst_d          <= 1'b0;
            link_req_valid <= 1'b0;
            link_req_state <= '0;
        end else begin
            rst_d          <= rst_q;
            link_req_valid <= wr_en & stb_wr;
            if (wr_en && stb_wr)
                link_req_state <= ls_wr;

            if (wr_en) begin
                pwr_q  <= pwr_wr;
                wake_q <= wake_wr;
                if (led_legal(led_wr))
                    led_q <= led_e'(led_wr);
                if (stb_wr)
                    ls_q <= ls_wr;
                if (rst_go && pwr_q && !rst_q)
                    rst_q <= 1'b1;
                if (warm_go && pwr_q && !warm_q) begin
                    warm_q <= 1'b1;
                    rst_q  <= 1'b1;
                end
            end

            if (hot_fin) begin
                rst_q <= 1'b0;
                en_q  <= 1'b1;
                spd_q <= hw_speed;
            end
            if (warm_fin) begin
                warm_q <= 1'b0;
                rst_q  <= 1'b0;
                en_q   <= 1'b1;
                spd_q  <= hw_speed;
            end

            // hardware report outranks the software strobe
            if (hw_link_chg)
                ls_q <= hw_link_state;

            // detach outranks everything else
            if (disc) begin
                en_q   <= 1'b0;
                spd_q  <= '0;
                rst_q  <= 1'b0;
                warm_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rport_chg.sv
module rport_chg
    import rport_pkg::*;
#(
    parameter int N = CHG_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (wr_en && clr[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rport_ctl.sv
module rport_ctl
    import rport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              hw_connect,
    input  logic              hw_overcurrent,
    input  logic [SPD_W-1:0]  hw_speed,
    input  logic              hw_link_chg,
    input  logic [LS_W-1:0]   hw_link_state,
    input  logic              hw_reset_done,
    input  logic              hw_warm_done,
    input  logic              hw_cfg_err,
    output logic              port_power,
    output logic              reset_req,
    output logic              warm_req,
    output logic              link_req_valid,
    output logic [LS_W-1:0]   link_req_state,
    output logic [LED_W-1:0]  led_code
);
    logic conn_q, oc_q, conn_tgl, oc_tgl, disc;
    logic en_drop, warm_fin, rst_fell;
    logic [CHG_N-1:0] chg_set, chg_flags;
    port_state_t st;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[B_CONN], wr_data[B_EN], wr_data[2], wr_data[B_OC],
                              wr_data[B_SPD +: SPD_W], wr_data[24], wr_data[30:28]};

    rport_sense u_sense (
        .clk            (clk),
        .rst            (rst),
        .hw_connect     (hw_connect),
        .hw_overcurrent (hw_overcurrent),
        .conn_q         (conn_q),
        .oc_q           (oc_q),
        .conn_tgl       (conn_tgl),
        .oc_tgl         (oc_tgl),
        .disc           (disc)
    );

    rport_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .pwr_wr         (wr_data[B_PWR]),
        .led_wr         (wr_data[B_LED +: LED_W]),
        .wake_wr        (wr_data[B_WAKE +: WAKE_W]),
        .rst_go         (wr_data[B_RST]),
        .warm_go        (wr_data[B_WARM]),
        .stb_wr         (wr_data[B_STB]),
        .ls_wr          (wr_data[B_LS +: LS_W]),
        .disc           (disc),
        .hw_reset_done  (hw_reset_done),
        .hw_warm_done   (hw_warm_done),
        .hw_link_chg    (hw_link_chg),
        .hw_link_state  (hw_link_state),
        .hw_speed       (hw_speed),
        .en_q           (st.en),
        .rst_q          (st.rst),
        .warm_q         (st.warm),
        .pwr_q          (st.pwr),
        .ls_q           (st.ls),
        .spd_q          (st.spd),
        .led_q          (st.led),
        .wake_q         (st.wake),
        .link_req_valid (link_req_valid),
        .link_req_state (link_req_state),
        .en_drop        (en_drop),
        .warm_fin       (warm_fin),
        .rst_fell       (rst_fell)
    );

    assign st.conn = conn_q;
    assign st.oc   = oc_q;

    always_comb begin
        chg_set         = '0;
        chg_set[C_CONN] = conn_tgl;
        chg_set[C_EN]   = en_drop;
        chg_set[C_WARM] = warm_fin;
        chg_set[C_OC]   = oc_tgl;
        chg_set[C_RST]  = rst_fell;
        chg_set[C_LINK] = hw_link_chg;
        chg_set[C_CFG]  = hw_cfg_err;
    end

    rport_chg #(.N(CHG_N)) u_chg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .clr   (wr_data[B_CHG +: CHG_N]),
        .set   (chg_set),
        .flags (chg_flags)
    );

    assign rd_data    = pack_dword(st, chg_flags);
    assign port_power = st.pwr;
    assign reset_req  = st.rst & ~st.warm;
    assign warm_req   = st.warm;
    assign led_code   = st.led;
endmodule

// File: rtl/rport_chk.sv
module rport_chk
    import rport_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             hw_connect,
    input logic             port_power,
    input logic             warm_req,
    input logic             link_req_valid
);
    assert_sticky_conn_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_data[B_CHG + C_CONN] && !(wr_en && wr_data[B_CHG + C_CONN])) |=> rd_data[B_CHG + C_CONN]);

    assert_power_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[B_RST]) |-> $past(port_power));

    assert_fall_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data[B_RST]) |=> rd_data[B_CHG + C_RST]);

    assert_warm_pair_R6: assert property (@(posedge clk) disable iff (rst)
        warm_req |-> (rd_data[B_RST] && rd_data[B_WARM]));

    assert_detach_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_data[B_CONN] && !hw_connect) |=> !rd_data[B_EN]);

    assert_strobe_only_R8: assert property (@(posedge clk) disable iff (rst)
        link_req_valid |-> $past(wr_en && wr_data[B_STB]));
endmodule

bind rport_ctl rport_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .hw_connect     (hw_connect),
    .port_power     (port_power),
    .warm_req       (warm_req),
    .link_req_valid (link_req_valid)
);

// File: tb/sim_rport_ctl.sv
`timescale 1ns/1ps
module sim_rport_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        hw_connect = 1'b0, hw_overcurrent = 1'b0;
    logic [3:0]  hw_speed = '0, hw_link_state = '0;
    logic        hw_link_chg = 1'b0, hw_reset_done = 1'b0, hw_warm_done = 1'b0, hw_cfg_err = 1'b0;
    logic        port_power, reset_req, warm_req, link_req_valid;
    logic [3:0]  link_req_state;
    logic [1:0]  led_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    localparam logic [31:0] BASE = 32'h0E00_0200; // power on, all wake enables

    always #4 clk = ~clk;

    rport_ctl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .hw_connect(hw_connect), .hw_overcurrent(hw_overcurrent), .hw_speed(hw_speed),
        .hw_link_chg(hw_link_chg), .hw_link_state(hw_link_state),
        .hw_reset_done(hw_reset_done), .hw_warm_done(hw_warm_done), .hw_cfg_err(hw_cfg_err),
        .port_power(port_power), .reset_req(reset_req), .warm_req(warm_req),
        .link_req_valid(link_req_valid), .link_req_state(link_req_state), .led_code(led_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset();
        chk("R1 read value", rd_data, 32'h0000_00A0);
        chk("R1 outputs", {27'd0, port_power, reset_req, warm_req, link_req_valid, |led_code},
            32'd0);
    endtask

    task automatic t_power();
        wr(32'h0000_0010);
        chk("R4 reset ignored unpowered", {31'd0, reset_req}, 32'd0);
        chk("R4 bit4 unpowered", {31'd0, rd_data[4]}, 32'd0);
        wr(32'h7F00_0204);
        chk("R11 power wake reserved", rd_data, 32'h0E00_02A0);
        chk("R11 port_power", {31'd0, port_power}, 32'd1);
    endtask

    task automatic t_connect();
        hw_connect = 1'b1;
        tick();
        chk("R2 connect bit", {31'd0, rd_data[0]}, 32'd1);
        chk("R2 connect change", {31'd0, rd_data[17]}, 32'd1);
        wr(BASE | (32'd1 << 17));
        chk("R3 w1c clears", {31'd0, rd_data[17]}, 32'd0);
    endtask

    task automatic t_hot_reset();
        hw_speed = 4'd3;
        wr(BASE | 32'h10);
        chk("R4 reset_req", {30'd0, reset_req, warm_req}, 32'd2);
        chk("R4 bit4", {31'd0, rd_data[4]}, 32'd1);
        hw_reset_done = 1'b1;
        tick();
        hw_reset_done = 1'b0;
        chk("R5 bit4 cleared", {31'd0, rd_data[4]}, 32'd0);
        chk("R5 enabled", {31'd0, rd_data[1]}, 32'd1);
        chk("R5 speed", {28'd0, rd_data[13:10]}, 32'd3);
        chk("R5 flag not yet", {31'd0, rd_data[21]}, 32'd0);
        tick();
        chk("R5 reset change", {31'd0, rd_data[21]}, 32'd1);
        chk("R5 no warm change", {31'd0, rd_data[19]}, 32'd0);
        wr(BASE | (32'd1 << 21));
    endtask

    task automatic t_disconnect();
        // detach in the same cycle as a clearing write of connect-change
        hw_connect = 1'b0;
        wr_en = 1'b1;
        wr_data = BASE | (32'd1 << 17);
        tick();
        wr_en = 1'b0;
        wr_data = '0;
        chk("R3 set beats clear", {31'd0, rd_data[17]}, 32'd1);
        chk("R7 enable dropped", {31'd0, rd_data[1]}, 32'd0);
        chk("R7 enable change", {31'd0, rd_data[18]}, 32'd1);
        chk("R7 speed cleared", {28'd0, rd_data[13:10]}, 32'd0);
        chk("R2 connect low", {31'd0, rd_data[0]}, 32'd0);
        wr(BASE | 32'h00FE_0000);
        hw_connect = 1'b1;
        tick();
        hw_connect = 1'b0;
        tick();
        chk("R7 no change when disabled", {31'd0, rd_data[18]}, 32'd0);
        wr(BASE | 32'h00FE_0000);
    endtask

    task automatic t_warm();
        hw_connect = 1'b1;
        tick();
        hw_speed = 4'd4;
        wr(BASE | (32'd1 << 31));
        chk("R6 requests", {30'd0, reset_req, warm_req}, 32'd1);
        chk("R6 bits 31 and 4", {30'd0, rd_data[31], rd_data[4]}, 32'd3);
        hw_reset_done = 1'b1;
        tick();
        hw_reset_done = 1'b0;
        chk("R6 hot done ignored", {30'd0, rd_data[31], rd_data[4]}, 32'd3);
        hw_warm_done = 1'b1;
        tick();
        hw_warm_done = 1'b0;
        chk("R6 bits cleared", {30'd0, rd_data[31], rd_data[4]}, 32'd0);
        chk("R6 warm change", {31'd0, rd_data[19]}, 32'd1);
        chk("R6 enabled speed", {27'd0, rd_data[1], rd_data[13:10]}, 32'h14);
        tick();
        chk("R6 reset change", {31'd0, rd_data[21]}, 32'd1);
        wr(BASE | 32'h00FE_0000);
    endtask

    task automatic t_link();
        wr(BASE | (32'd7 << 5));
        chk("R8 no strobe field", {28'd0, rd_data[8:5]}, 32'd5);
        chk("R8 no strobe request", {31'd0, link_req_valid}, 32'd0);
        wr(BASE | (32'd1 << 16) | (32'd2 << 5));
        chk("R8 strobe field", {28'd0, rd_data[8:5]}, 32'd2);
        chk("R8 request", {27'd0, link_req_valid, link_req_state}, 32'h12);
        chk("R8 bit16 reads 0", {31'd0, rd_data[16]}, 32'd0);
        tick();
        chk("R8 one cycle", {31'd0, link_req_valid}, 32'd0);
        hw_link_chg = 1'b1;
        hw_link_state = 4'd3;
        wr(BASE | (32'd1 << 16) | (32'd7 << 5));
        hw_link_chg = 1'b0;
        chk("R9 hardware wins field", {28'd0, rd_data[8:5]}, 32'd3);
        chk("R9 link change", {31'd0, rd_data[22]}, 32'd1);
        chk("R9 request kept", {27'd0, link_req_valid, link_req_state}, 32'h17);
        wr(BASE | (32'd1 << 22));
        hw_link_chg = 1'b1;
        hw_link_state = 4'd0;
        tick();
        hw_link_chg = 1'b0;
        chk("R9 report alone", {27'd0, rd_data[22], rd_data[8:5]}, 32'h10);
    endtask

    task automatic t_oc_cfg();
        hw_overcurrent = 1'b1;
        tick();
        chk("R2 oc bit and change", {30'd0, rd_data[3], rd_data[20]}, 32'd3);
        wr(BASE);
        chk("R3 write zero keeps", {31'd0, rd_data[20]}, 32'd1);
        wr(BASE | (32'd1 << 20));
        chk("R3 oc change cleared", {31'd0, rd_data[20]}, 32'd0);
        hw_overcurrent = 1'b0;
        tick();
        chk("R2 oc falling change", {30'd0, rd_data[3], rd_data[20]}, 32'd1);
        hw_cfg_err = 1'b1;
        tick();
        hw_cfg_err = 1'b0;
        chk("R2 config error change", {31'd0, rd_data[23]}, 32'd1);
    endtask

    task automatic t_led();
        wr(BASE | (32'd1 << 14));
        chk("R10 amber", {28'd0, rd_data[15:14], led_code}, 32'h5);
        wr(BASE | (32'd2 << 14));
        chk("R10 green", {28'd0, rd_data[15:14], led_code}, 32'hA);
        wr(BASE | (32'd3 << 14));
        chk("R10 code 3 ignored", {28'd0, rd_data[15:14], led_code}, 32'hA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_power();
        t_connect();
        t_hot_reset();
        t_disconnect();
        t_warm();
        t_link();
        t_oc_cfg();
        t_led();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule